// File: doc/BRIEF.md
# Edge-Latched Interrupt Cause and Mask Aggregator

This block gathers six event pulses into one interrupt line for a parent interrupt controller. Each source bit has a fixed position: 0 is the self/doorbell event, 1 is timer 0, 2 is timer 1, 3 is the watchdog, 4 is an access error and 5 is a 64-bit bus error. The block watches each source for a rising edge and holds any edge it sees in a cause register. A second register, the enable mask, decides which held causes may reach the single combined output.

Software reaches the two registers over a plain 32-bit register bus. The cause register is at byte offset 0 and the mask register at byte offset 4. To acknowledge a cause, software writes a word with a 0 in that bit's position. Every position written as 1 keeps its old value, so one source can be acknowledged without disturbing the others. The combined output is registered. It is high while at least one cause bit and its matching mask bit are both set.

Top module: `irq_cause_gate`

## Requirements
- R1: After reset, the cause register reads 0, the mask register reads 0 and `irq_out` is 0.
- R2: A 0-to-1 transition on `src_evt[n]`, sampled at a clock edge, sets cause bit n at that edge. A source that stays high sets the bit only once, so a bit acknowledged while its source is still high stays clear.
- R3: Source positions are fixed. `src_evt[0]` is self/doorbell, [1] timer 0, [2] timer 1, [3] watchdog, [4] access error and [5] 64-bit bus error, and each sets only the cause bit of the same index.
- R4: A write to offset 0 clears every cause bit whose data bit is 0 and leaves every bit written as 1 unchanged. Writing 0 clears all causes.
- R5: A write to offset 4 loads mask bits [5:0] from the write data, and a read of offset 4 returns them. Writing the mask never changes the cause register.
- R6: `irq_out` equals the OR-reduction of (cause AND mask) as it stood one clock earlier.
- R7: When a rising edge on source n and a cause write with bit n at 0 fall in the same cycle, cause bit n ends set.
- R8: Bits [31:6] of both registers read as 0 whatever was written. Reads of offsets 8 and 12 return 0, and writes there change nothing.
- R9: A read of offset 0 returns the raw latched causes, including bits whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 6 | Event sources, one per cause bit |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte offset: 0 selects cause, 4 selects mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
Sparse random source pulses run together with random writes to all four offsets. Most cause writes carry mostly-one data, so the run tells partial acknowledges apart from full clears. Directed sequences then pulse each source alone, which separates bit positions from one another. A source is held high across an acknowledge to tell edge capture apart from level capture. A set and a clear are placed in the same cycle to show which one wins. The mask is changed with causes pending, which tells the raw cause readback apart from the gated output and confirms the one-cycle delay of the output.

// File: rtl/irq_cg_pkg.sv
package irq_cg_pkg;
    localparam int NSRC     = 6;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int CAUSE_OFF = 0;
    localparam int MASK_OFF  = 4;

    typedef enum int {
        SRC_SELF     = 0,
        SRC_TMR0     = 1,
        SRC_TMR1     = 2,
        SRC_WDOG     = 3,
        SRC_ACC_ERR  = 4,
        SRC_BUS64ERR = 5
    } src_idx_e;
endpackage

// File: rtl/icg_edge_cap.sv
module icg_edge_cap #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
        for (int i = 0; i < N; i++) begin
            rise_o[i] = src_i[i] & ~st_q.prev[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/icg_regs.sv
module icg_regs
    import irq_cg_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rise_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [N-1:0]  cause_o,
    output logic [N-1:0]  mask_o,
    output logic [DW-1:0] rdata_o
);
    localparam logic [AW-1:0] A_CAUSE = AW'(CAUSE_OFF);
    localparam logic [AW-1:0] A_MASK  = AW'(MASK_OFF);

    typedef struct packed {
        logic [N-1:0] cause;
        logic [N-1:0] mask;
    } st_t;

    st_t st_d, st_q;
    logic hit_cause, hit_mask;
    logic unused_hi;

    assign unused_hi = ^wdata_i[DW-1:N];

    always_comb begin
        st_d      = st_q;
        hit_cause = wr_i && (addr_i == A_CAUSE);
        hit_mask  = wr_i && (addr_i == A_MASK);
        for (int i = 0; i < N; i++) begin
            // clear-on-zero, then a fresh edge sets the bit and wins
            st_d.cause[i] = (hit_cause ? (st_q.cause[i] & wdata_i[i]) : st_q.cause[i])
                            | rise_i[i];
        end
        if (hit_mask) st_d.mask = wdata_i[N-1:0];

        rdata_o = '0;
        if (addr_i == A_CAUSE)     rdata_o[N-1:0] = st_q.cause;
        else if (addr_i == A_MASK) rdata_o[N-1:0] = st_q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
endmodule

// File: rtl/icg_irq_out.sv
module icg_irq_out #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(cause_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_cause_gate.sv
module irq_cause_gate
    import irq_cg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [NSRC-1:0] rise_w;
    logic [NSRC-1:0] cause_w;
    logic [NSRC-1:0] mask_w;

    icg_edge_cap #(.N(NSRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_evt),
        .rise_o (rise_w)
    );

    icg_regs #(.N(NSRC), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .cause_o (cause_w),
        .mask_o  (mask_w),
        .rdata_o (bus_rdata)
    );

    icg_irq_out #(.N(NSRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_w),
        .mask_i  (mask_w),
        .irq_o   (irq_out)
    );
endmodule

// File: rtl/irq_cause_gate_chk.sv
module irq_cause_gate_chk
    import irq_cg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   rise_w,
    input logic [NSRC-1:0]   cause_w,
    input logic [NSRC-1:0]   mask_w,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out
);
    // R6
    irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(cause_w & mask_w)));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w != '0) |=> ((cause_w & $past(rise_w)) == $past(rise_w)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_w & ~$past(cause_w) & ~$past(rise_w)) == '0));

    // R5
    mask_keeps_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(MASK_OFF)) |=>
            (cause_w == ($past(cause_w) | $past(rise_w))));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NSRC] == '0);
endmodule

bind irq_cause_gate irq_cause_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_w    (rise_w),
    .cause_w   (cause_w),
    .mask_w    (mask_w),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
);

// File: tb/irq_cause_gate_tb_top.sv
module irq_cause_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_evt = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [5:0] m_cause, m_mask, m_prev;
    logic       m_irq;

    always #5 clk = ~clk;

    irq_cause_gate dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [5:0] next_cause(logic [5:0] c, logic [5:0] p, logic [5:0] s,
                                              logic w, logic [3:0] a, logic [31:0] d);
        logic [5:0] r = s & ~p;
        return ((w && a == 4'd0) ? (c & d[5:0]) : c) | r;
    endfunction

    function automatic logic [5:0] next_mask(logic [5:0] m, logic w, logic [3:0] a, logic [31:0] d);
        return (w && a == 4'd4) ? d[5:0] : m;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle from a negedge, update model at the posedge, return at next negedge
    task automatic cycle(logic [5:0] s, logic w, logic [3:0] a, logic [31:0] d);
        src_evt = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        m_irq   = |(m_cause & m_mask);
        m_cause = next_cause(m_cause, m_prev, s, w, a, d);
        m_mask  = next_mask(m_mask, w, a, d);
        m_prev  = s;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_all(string req);
        bus_wr = 1'b0;
        bus_addr = 4'd0; #1; chk(req, bus_rdata, {26'd0, m_cause});
        bus_addr = 4'd4; #1; chk(req, bus_rdata, {26'd0, m_mask});
        bus_addr = 4'd8; #1; chk("R8", bus_rdata, 32'd0);
        chk(req, {31'd0, irq_out}, {31'd0, m_irq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1c6a));
        m_cause = '0; m_mask = '0; m_prev = '0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3: each source alone lands at its own index
        for (int n = 0; n < 6; n++) begin
            cycle(6'(1 << n), 0, 0, 0);
            bus_addr = 4'd0; #1;
            chk("R3", bus_rdata, 32'(1) << n);
            cycle(6'd0, 1, 4'd0, 32'd0);
            check_all("R4");
        end

        // R9: raw causes visible with mask off, irq stays low
        cycle(6'b101010, 0, 0, 0);
        cycle(6'd0, 0, 0, 0);
        check_all("R9");
        chk("R9", {31'd0, irq_out}, 32'd0);

        // R5/R6: enable mask, irq one cycle later; mask write keeps cause
        cycle(6'd0, 1, 4'd4, 32'hFFFF_FFC2);
        check_all("R5");
        chk("R6", {31'd0, irq_out}, 32'd0);
        cycle(6'd0, 0, 0, 0);
        check_all("R6");
        chk("R6", {31'd0, irq_out}, 32'd1);
        chk("R8", {26'd0, m_mask}, 32'h02);

        // R4: ack bit 1 only, keep others
        cycle(6'd0, 1, 4'd0, ~32'h2);
        check_all("R4");
        chk("R4", {26'd0, m_cause}, 32'h28);
        cycle(6'd0, 0, 0, 0);
        check_all("R6");
        chk("R6", {31'd0, irq_out}, 32'd0);

        // R8: unmapped writes ignored
        cycle(6'd0, 1, 4'd8, 32'h0);
        cycle(6'd0, 1, 4'd12, 32'h0);
        check_all("R8");

        // R2: held-high source sets once
        cycle(6'b000100, 1, 4'd0, 32'd0);
        check_all("R2");
        cycle(6'b000100, 1, 4'd0, ~32'h4);
        cycle(6'b000100, 0, 0, 0);
        check_all("R2");
        chk("R2", {26'd0, m_cause} & 32'h4, 32'h0);

        // R7: edge and clear in one cycle
        cycle(6'b000000, 0, 0, 0);
        cycle(6'b001000, 0, 0, 0);
        cycle(6'b000000, 0, 0, 0);
        cycle(6'b001000, 1, 4'd0, 32'h0);
        check_all("R7");
        chk("R7", {26'd0, m_cause} & 32'h8, 32'h8);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [5:0]  s;
            logic        w;
            logic [3:0]  a;
            logic [31:0] d;
            s = 6'($urandom) & 6'($urandom) & 6'($urandom);
            w = ($urandom % 10) < 3;
            a = 4'(($urandom % 4) * 4);
            d = ($urandom % 4 == 0) ? $urandom : ~(32'(1) << ($urandom % 6));
            cycle(s, w, a, d);
            check_all("R2 R4 R5 R6");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule